// File: doc/BRIEF.md
# Sleep Entry and Wakeup Controller

This block decides when a processor core stops its clock and when it starts it again. The core signals a wait-for-interrupt or wait-for-event execution with a one-cycle strobe. It also signals, with its own strobe, the return from the lowest-priority handler. Two configuration levels select the entry rule and the wake rule. The first makes sleep begin on that handler return rather than at the wait instruction. The second lets an interrupt that is masked in the interrupt controller serve as a wake event.

Interrupt requests arrive as one-cycle strobes, one per line, together with an enable mask from the interrupt controller. Each line has two sticky pending bits, one on the peripheral side and one on the controller side, each cleared by its own strobe. Event-mode external lines wake a core waiting for an event, and they set no pending bit. Three groups of peripheral clock enables, for one high-speed bus and two peripheral buses, are taken from their enable registers and registered before they leave the block. They follow those registers both while the core runs and while it sleeps. While the core sleeps its clock is off, so the outputs it drives, I/O included, hold their values.

All pins are plain control and status levels or strobes. No data stream crosses the block edge, so no valid/ready handshake and no back-pressure apply.

Top module: `slp_wake_ctrl`

## Requirements
- R1: After reset the core clock enable is 1, sleeping and wake are 0, all pending bits are 0, and all peripheral clock enables are 0.
- R2: With sleep-on-exit clear, a wait-irq or wait-event strobe in cycle N gives sleeping=1 from cycle N+1. Provided no event is already held, the core clock enable is 0 from cycle N+1 until a wake.
- R3: With sleep-on-exit set, wait-irq and wait-event strobes are ignored and the core stays awake. A handler-return strobe in cycle N gives sleeping=1 from cycle N+1. That sleep follows the wait-irq wake rule.
- R4: A sleep entered through wait-irq (or handler return) ends only for an interrupt line whose enable bit is 1 and that is requesting or controller-pending. Event lines and masked interrupts do not end it.
- R5: A sleep entered through wait-event ends on any event-line strobe, and no pending bit is set by it.
- R6: When send-event-on-pending is 1, a request on a line whose enable bit is 0 is a wake event. Both of its pending bits stay 1 after the wake until their clear strobes. When send-event-on-pending is 0, such a request does not wake the core.
- R7: In the cycle the wake condition appears at the inputs, wake=1 and the core clock enable is 1 while sleeping is still 1. Wake lasts exactly one cycle, and sleeping is 0 from the next cycle.
- R8: An event seen while awake, or while sleeping through wait-irq, is held. A later wait-event strobe with an event held does not enter sleep and consumes the event, so the following wait-event strobe enters sleep.
- R9: A request strobe on line i sets both pending bits of line i from the next cycle. Each bit stays set until its own clear strobe, and a set in the same cycle as a clear wins.
- R10: Each peripheral clock enable output equals its enable register input one cycle earlier, both while awake and while sleeping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wait_irq_i | input | 1 | Wait-for-interrupt executed (strobe) |
| wait_evt_i | input | 1 | Wait-for-event executed (strobe) |
| exc_ret_i | input | 1 | Return from lowest-priority handler (strobe) |
| sleep_on_exit_i | input | 1 | Enter sleep on handler return instead of at wait instructions |
| sev_on_pend_i | input | 1 | Masked interrupt requests count as wake events |
| irq_req_i | input | N_IRQ | Per-line interrupt request strobes |
| irq_en_i | input | N_IRQ | Interrupt controller enable mask |
| dev_pend_clr_i | input | N_IRQ | Peripheral-side pending clear strobes |
| ctl_pend_clr_i | input | N_IRQ | Controller-side pending clear strobes |
| evt_line_i | input | N_EVL | Event-mode external line strobes |
| ahb_en_i | input | N_AHB | High-speed bus clock enable register |
| apb1_en_i | input | N_APB1 | First peripheral bus clock enable register |
| apb2_en_i | input | N_APB2 | Second peripheral bus clock enable register |
| core_clk_en_o | output | 1 | Core clock enable |
| ahb_clk_en_o | output | N_AHB | High-speed bus peripheral clock enables |
| apb1_clk_en_o | output | N_APB1 | First peripheral bus clock enables |
| apb2_clk_en_o | output | N_APB2 | Second peripheral bus clock enables |
| sleeping_o | output | 1 | Core is asleep |
| wake_o | output | 1 | One-cycle wake pulse |
| dev_pend_o | output | N_IRQ | Peripheral-side pending bits |
| ctl_pend_o | output | N_IRQ | Controller-side pending bits |

## Verification
Each entry path is paired with each wake source in the test sequence. A wait-irq sleep is hit first by an event-line strobe and then by a masked request, and neither may wake it. An enabled request then must wake it. This separates the two wake rules. A wait-event sleep is woken by an event line, and then by a masked request with send-event-on-pending both cleared and set. Comparing the pending bits after each wake shows that event lines leave nothing to clear, while masked requests leave both pending bits set. The held-event sequence, wait-event strobes under sleep-on-exit, and an enable-register change during sleep show that the block distinguishes entry that is refused, entry that is ignored, and clocks that keep following their registers.

// File: rtl/slp_pkg.sv
package slp_pkg;
  typedef enum logic {
    ST_RUN   = 1'b0,
    ST_SLEEP = 1'b1
  } slp_state_e;

  typedef enum logic {
    VIA_IRQ = 1'b0,
    VIA_EVT = 1'b1
  } slp_via_e;
endpackage

// File: rtl/slp_pend_bank.sv
module slp_pend_bank #(
  parameter int N_IRQ = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] irq_req_i,
  input  logic [N_IRQ-1:0] irq_en_i,
  input  logic [N_IRQ-1:0] dev_clr_i,
  input  logic [N_IRQ-1:0] ctl_clr_i,
  input  logic             sev_on_pend_i,
  output logic [N_IRQ-1:0] dev_pend_o,
  output logic [N_IRQ-1:0] ctl_pend_o,
  output logic             irq_wake_o,
  output logic             sev_evt_o
);
  // one pair of sticky bits per line; a new request beats a clear
  for (genvar i = 0; i < N_IRQ; i++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dev_pend_o[i] <= 1'b0;
        ctl_pend_o[i] <= 1'b0;
      end else begin
        dev_pend_o[i] <= irq_req_i[i] | (dev_pend_o[i] & ~dev_clr_i[i]);
        ctl_pend_o[i] <= irq_req_i[i] | (ctl_pend_o[i] & ~ctl_clr_i[i]);
      end
    end
  end

  // an enabled line that requests now or is still pending at the controller
  assign irq_wake_o = |((irq_req_i | ctl_pend_o) & irq_en_i);
  // a fresh request on a masked line, turned into an event when allowed
  assign sev_evt_o  = sev_on_pend_i & |(irq_req_i & ~irq_en_i);
endmodule

// File: rtl/slp_evt_latch.sv
module slp_evt_latch #(
  parameter int N_EVL = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVL-1:0] evt_line_i,
  input  logic             sev_evt_i,
  input  logic             consume_i,
  output logic             ev_new_o,
  output logic             ev_held_o
);
  assign ev_new_o = (|evt_line_i) | sev_evt_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ev_held_o <= 1'b0;
    else if (consume_i) ev_held_o <= 1'b0;
    else                ev_held_o <= ev_held_o | ev_new_o;
  end
endmodule

// File: rtl/slp_entry_fsm.sv
module slp_entry_fsm
  import slp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wait_irq_i,
  input  logic wait_evt_i,
  input  logic exc_ret_i,
  input  logic sleep_on_exit_i,
  input  logic irq_wake_i,
  input  logic ev_new_i,
  input  logic ev_held_i,
  output logic sleeping_o,
  output logic core_clk_en_o,
  output logic wake_o,
  output logic consume_o
);
  slp_state_e state_q;
  slp_via_e   via_q;
  logic go_irq, go_evt, evt_ready, wake_now;

  always_comb begin
    go_irq    = sleep_on_exit_i ? exc_ret_i : wait_irq_i;
    go_evt    = !sleep_on_exit_i && wait_evt_i && !wait_irq_i;
    evt_ready = ev_new_i | ev_held_i;
    wake_now  = (state_q == ST_SLEEP) &&
                (irq_wake_i || ((via_q == VIA_EVT) && evt_ready));
    consume_o = ((state_q == ST_RUN) && go_evt && evt_ready) ||
                ((state_q == ST_SLEEP) && (via_q == VIA_EVT) && wake_now);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      via_q   <= VIA_IRQ;
    end else begin
      unique case (state_q)
        ST_RUN: begin
          if (go_irq) begin
            state_q <= ST_SLEEP;
            via_q   <= VIA_IRQ;
          end else if (go_evt && !evt_ready) begin
            state_q <= ST_SLEEP;
            via_q   <= VIA_EVT;
          end
        end
        ST_SLEEP: begin
          if (wake_now) state_q <= ST_RUN;
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end

  assign sleeping_o    = (state_q == ST_SLEEP);
  assign core_clk_en_o = (state_q == ST_RUN) || wake_now;
  assign wake_o        = wake_now;
endmodule

// File: rtl/slp_clk_gate.sv
module slp_clk_gate #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] en_reg_i,
  output logic [W-1:0] en_o
);
  // registered so a register write never glitches a gate enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_o <= '0;
    else        en_o <= en_reg_i;
  end
endmodule

// File: rtl/slp_wake_ctrl.sv
module slp_wake_ctrl #(
  parameter int N_IRQ  = 8,
  parameter int N_EVL  = 4,
  parameter int N_AHB  = 4,
  parameter int N_APB1 = 8,
  parameter int N_APB2 = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wait_irq_i,
  input  logic              wait_evt_i,
  input  logic              exc_ret_i,
  input  logic              sleep_on_exit_i,
  input  logic              sev_on_pend_i,
  input  logic [N_IRQ-1:0]  irq_req_i,
  input  logic [N_IRQ-1:0]  irq_en_i,
  input  logic [N_IRQ-1:0]  dev_pend_clr_i,
  input  logic [N_IRQ-1:0]  ctl_pend_clr_i,
  input  logic [N_EVL-1:0]  evt_line_i,
  input  logic [N_AHB-1:0]  ahb_en_i,
  input  logic [N_APB1-1:0] apb1_en_i,
  input  logic [N_APB2-1:0] apb2_en_i,
  output logic              core_clk_en_o,
  output logic [N_AHB-1:0]  ahb_clk_en_o,
  output logic [N_APB1-1:0] apb1_clk_en_o,
  output logic [N_APB2-1:0] apb2_clk_en_o,
  output logic              sleeping_o,
  output logic              wake_o,
  output logic [N_IRQ-1:0]  dev_pend_o,
  output logic [N_IRQ-1:0]  ctl_pend_o
);
  logic irq_wake, sev_evt, ev_new, ev_held, consume;

  slp_pend_bank #(.N_IRQ(N_IRQ)) u_pend (
    .clk           (clk),
    .rst_n         (rst_n),
    .irq_req_i     (irq_req_i),
    .irq_en_i      (irq_en_i),
    .dev_clr_i     (dev_pend_clr_i),
    .ctl_clr_i     (ctl_pend_clr_i),
    .sev_on_pend_i (sev_on_pend_i),
    .dev_pend_o    (dev_pend_o),
    .ctl_pend_o    (ctl_pend_o),
    .irq_wake_o    (irq_wake),
    .sev_evt_o     (sev_evt)
  );

  slp_evt_latch #(.N_EVL(N_EVL)) u_evt (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_line_i (evt_line_i),
    .sev_evt_i  (sev_evt),
    .consume_i  (consume),
    .ev_new_o   (ev_new),
    .ev_held_o  (ev_held)
  );

  slp_entry_fsm u_fsm (
    .clk             (clk),
    .rst_n           (rst_n),
    .wait_irq_i      (wait_irq_i),
    .wait_evt_i      (wait_evt_i),
    .exc_ret_i       (exc_ret_i),
    .sleep_on_exit_i (sleep_on_exit_i),
    .irq_wake_i      (irq_wake),
    .ev_new_i        (ev_new),
    .ev_held_i       (ev_held),
    .sleeping_o      (sleeping_o),
    .core_clk_en_o   (core_clk_en_o),
    .wake_o          (wake_o),
    .consume_o       (consume)
  );

  slp_clk_gate #(.W(N_AHB)) u_gate_ahb (
    .clk (clk), .rst_n (rst_n), .en_reg_i (ahb_en_i), .en_o (ahb_clk_en_o)
  );
  slp_clk_gate #(.W(N_APB1)) u_gate_apb1 (
    .clk (clk), .rst_n (rst_n), .en_reg_i (apb1_en_i), .en_o (apb1_clk_en_o)
  );
  slp_clk_gate #(.W(N_APB2)) u_gate_apb2 (
    .clk (clk), .rst_n (rst_n), .en_reg_i (apb2_en_i), .en_o (apb2_clk_en_o)
  );
endmodule

// File: rtl/slp_wake_ctrl_chk.sv
module slp_wake_ctrl_chk #(
  parameter int N_IRQ = 8,
  parameter int N_AHB = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wait_irq_i,
  input logic             exc_ret_i,
  input logic             sleep_on_exit_i,
  input logic [N_IRQ-1:0] irq_req_i,
  input logic [N_IRQ-1:0] dev_pend_clr_i,
  input logic [N_AHB-1:0] ahb_en_i,
  input logic             core_clk_en_o,
  input logic [N_AHB-1:0] ahb_clk_en_o,
  input logic             sleeping_o,
  input logic             wake_o,
  input logic [N_IRQ-1:0] dev_pend_o
);
  p_clk_off_asleep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sleeping_o && !wake_o) |-> !core_clk_en_o);

  p_enter_now_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleeping_o && !sleep_on_exit_i && wait_irq_i) |=> sleeping_o);

  p_exit_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleeping_o && sleep_on_exit_i && !exc_ret_i) |=> !sleeping_o);

  p_enter_on_ret_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleeping_o && sleep_on_exit_i && exc_ret_i) |=> sleeping_o);

  p_wake_clk_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> (core_clk_en_o && sleeping_o));

  p_wake_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |=> (!wake_o && !sleeping_o));

  p_pend_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(dev_pend_o) & ~$past(dev_pend_clr_i) & ~dev_pend_o) == '0));

  p_pend_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_req_i) |=> ((dev_pend_o & $past(irq_req_i)) == $past(irq_req_i)));

  p_ahb_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ahb_clk_en_o == $past(ahb_en_i)));
endmodule

bind slp_wake_ctrl slp_wake_ctrl_chk #(.N_IRQ(N_IRQ), .N_AHB(N_AHB)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .wait_irq_i      (wait_irq_i),
  .exc_ret_i       (exc_ret_i),
  .sleep_on_exit_i (sleep_on_exit_i),
  .irq_req_i       (irq_req_i),
  .dev_pend_clr_i  (dev_pend_clr_i),
  .ahb_en_i        (ahb_en_i),
  .core_clk_en_o   (core_clk_en_o),
  .ahb_clk_en_o    (ahb_clk_en_o),
  .sleeping_o      (sleeping_o),
  .wake_o          (wake_o),
  .dev_pend_o      (dev_pend_o)
);

// File: tb/slp_wake_ctrl_bench.sv
module slp_wake_ctrl_bench;
  localparam int N_IRQ = 8, N_EVL = 4, N_AHB = 4, N_APB1 = 8, N_APB2 = 8;
  localparam int S_CORE = 0, S_SLP = 1, S_WAKE = 2, S_DPEND = 3, S_CPEND = 4,
                 S_AHB = 5, S_APB1 = 6, S_APB2 = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wait_irq = 0, wait_evt = 0, exc_ret = 0, soe = 0, sevp = 0;
  logic [N_IRQ-1:0] irq_req = '0, irq_en = '0, dev_clr = '0, ctl_clr = '0;
  logic [N_EVL-1:0] evt_line = '0;
  logic [N_AHB-1:0] ahb_en = '0;
  logic [N_APB1-1:0] apb1_en = '0;
  logic [N_APB2-1:0] apb2_en = '0;
  logic core_clk_en, sleeping, wake;
  logic [N_AHB-1:0] ahb_clk_en;
  logic [N_APB1-1:0] apb1_clk_en;
  logic [N_APB2-1:0] apb2_clk_en;
  logic [N_IRQ-1:0] dev_pend, ctl_pend;

  always #5 clk = ~clk;

  slp_wake_ctrl #(.N_IRQ(N_IRQ), .N_EVL(N_EVL), .N_AHB(N_AHB),
                  .N_APB1(N_APB1), .N_APB2(N_APB2)) u_slp_wake_ctrl (
    .clk (clk), .rst_n (rst_n),
    .wait_irq_i (wait_irq), .wait_evt_i (wait_evt), .exc_ret_i (exc_ret),
    .sleep_on_exit_i (soe), .sev_on_pend_i (sevp),
    .irq_req_i (irq_req), .irq_en_i (irq_en),
    .dev_pend_clr_i (dev_clr), .ctl_pend_clr_i (ctl_clr),
    .evt_line_i (evt_line), .ahb_en_i (ahb_en), .apb1_en_i (apb1_en),
    .apb2_en_i (apb2_en), .core_clk_en_o (core_clk_en),
    .ahb_clk_en_o (ahb_clk_en), .apb1_clk_en_o (apb1_clk_en),
    .apb2_clk_en_o (apb2_clk_en), .sleeping_o (sleeping), .wake_o (wake),
    .dev_pend_o (dev_pend), .ctl_pend_o (ctl_pend)
  );

  typedef struct {
    string       tag;
    int          sig;
    logic [31:0] val;
  } exp_t;

  exp_t q[$];
  int total = 0, bad = 0;
  bit done = 0;

  function automatic logic [31:0] actual(int s);
    case (s)
      S_CORE:  return 32'(core_clk_en);
      S_SLP:   return 32'(sleeping);
      S_WAKE:  return 32'(wake);
      S_DPEND: return 32'(dev_pend);
      S_CPEND: return 32'(ctl_pend);
      S_AHB:   return 32'(ahb_clk_en);
      S_APB1:  return 32'(apb1_clk_en);
      default: return 32'(apb2_clk_en);
    endcase
  endfunction

  task automatic want(string tag, int sig, logic [31:0] v);
    exp_t e;
    e.tag = tag; e.sig = sig; e.val = v;
    q.push_back(e);
  endtask

  // next cycle: strobes return low, levels keep their values
  task automatic cyc();
    @(negedge clk);
    wait_irq = 0; wait_evt = 0; exc_ret = 0;
    irq_req = '0; evt_line = '0; dev_clr = '0; ctl_clr = '0;
  endtask

  // monitor: compares just before the next rising edge
  initial begin : monitor
    exp_t e;
    logic [31:0] a;
    forever begin
      @(negedge clk);
      #4;
      while (q.size() > 0) begin
        e = q.pop_front();
        a = actual(e.sig);
        total++;
        if (a !== e.val) begin
          bad++;
          $display("FAIL %s sig=%0d actual=%0h expected=%0h", e.tag, e.sig, a, e.val);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog R1..all actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    cyc();
    want("R1", S_CORE, 1); want("R1", S_SLP, 0); want("R1", S_WAKE, 0);
    want("R1", S_DPEND, 0); want("R1", S_CPEND, 0); want("R1", S_AHB, 0);
    want("R1", S_APB2, 0);

    // R2 sleep now through wait-irq
    cyc(); wait_irq = 1; want("R2", S_SLP, 0); want("R2", S_CORE, 1);
    cyc(); want("R2", S_SLP, 1); want("R2", S_CORE, 0);
    // R4 event line does not end a wait-irq sleep (event gets held)
    cyc(); evt_line = 4'h1; want("R4", S_WAKE, 0); want("R4", S_CORE, 0);
    // R4 masked request does not end it either
    cyc(); irq_req = 8'h04; want("R4", S_WAKE, 0);
    cyc(); want("R4", S_SLP, 1);
    want("R9", S_DPEND, 32'h04); want("R9", S_CPEND, 32'h04);
    cyc(); dev_clr = 8'h04; ctl_clr = 8'h04;
    cyc(); want("R9", S_DPEND, 0); want("R9", S_CPEND, 0);
    // R9 set wins over clear in the same cycle
    cyc(); irq_req = 8'h10; dev_clr = 8'h10;
    cyc(); want("R9", S_DPEND, 32'h10);
    cyc(); dev_clr = 8'h10; ctl_clr = 8'h10;
    // R4/R7 enabled request wakes
    cyc(); irq_req = 8'h20; irq_en = 8'h20;
    want("R7", S_WAKE, 1); want("R7", S_CORE, 1); want("R7", S_SLP, 1);
    cyc(); want("R7", S_WAKE, 0); want("R7", S_SLP, 0); want("R7", S_CORE, 1);
    cyc(); dev_clr = 8'h20; ctl_clr = 8'h20; irq_en = '0;

    // R8 held event refuses the first wait-event
    cyc(); wait_evt = 1;
    cyc(); want("R8", S_SLP, 0); want("R8", S_CORE, 1);
    cyc(); wait_evt = 1;
    cyc(); want("R8", S_SLP, 1); want("R2", S_CORE, 0);
    // R5 event line wakes a wait-event sleep without pending bits
    cyc(); evt_line = 4'h8; want("R5", S_WAKE, 1); want("R5", S_CORE, 1);
    cyc(); want("R5", S_SLP, 0); want("R5", S_DPEND, 0); want("R5", S_CPEND, 0);
    cyc(); wait_evt = 1;
    cyc(); want("R5", S_SLP, 1);
    cyc(); evt_line = 4'h1; want("R5", S_WAKE, 1);
    cyc(); want("R5", S_SLP, 0);

    // R6 masked request with send-event-on-pending clear: no wake
    cyc(); wait_evt = 1;
    cyc(); want("R6", S_SLP, 1);
    cyc(); irq_req = 8'h01; want("R6", S_WAKE, 0);
    cyc(); want("R6", S_SLP, 1);
    // R6 with it set: wake, pending bits remain
    sevp = 1; irq_req = 8'h02; want("R6", S_WAKE, 1);
    cyc(); want("R6", S_SLP, 0);
    want("R6", S_DPEND, 32'h03); want("R6", S_CPEND, 32'h03);
    cyc(); want("R6", S_DPEND, 32'h03); dev_clr = 8'h03; ctl_clr = 8'h03; sevp = 0;
    cyc(); want("R6", S_DPEND, 0); want("R6", S_CPEND, 0);

    // R3 sleep-on-exit ignores wait strobes
    soe = 1;
    cyc(); wait_irq = 1;
    cyc(); want("R3", S_SLP, 0);
    cyc(); wait_evt = 1;
    cyc(); want("R3", S_SLP, 0);
    cyc(); exc_ret = 1; want("R3", S_SLP, 0);
    cyc(); want("R3", S_SLP, 1); want("R3", S_CORE, 0);
    cyc(); evt_line = 4'h2; want("R3", S_WAKE, 0);
    cyc(); irq_req = 8'h80; irq_en = 8'h80; want("R3", S_WAKE, 1);
    cyc(); want("R3", S_SLP, 0);
    cyc(); dev_clr = 8'h80; ctl_clr = 8'h80; irq_en = '0; soe = 0;

    // R10 peripheral clock enables follow registers
    cyc(); ahb_en = 4'hA; apb1_en = 8'h5A; apb2_en = 8'hC3; want("R10", S_AHB, 0);
    cyc(); want("R10", S_AHB, 32'hA); want("R10", S_APB1, 32'h5A);
    want("R10", S_APB2, 32'hC3);
    wait_irq = 1;
    cyc(); want("R10", S_SLP, 1); apb2_en = 8'h0F;
    cyc(); want("R10", S_APB2, 32'h0F); want("R10", S_SLP, 1);
    irq_req = 8'h08; irq_en = 8'h08; want("R4", S_WAKE, 1);
    cyc(); want("R4", S_SLP, 0);
    cyc(); cyc();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule